// File: doc/BRIEF.md
# Fly-by Byte-Lane Leveling Delay

With fly-by routing, command and address reach the DRAM devices one after another along a single chain. Each device therefore answers a read, and expects write data, a little later than the device before it. This block keeps one whole-cycle delay for each of nine byte lanes: eight data lanes and one check-byte lane. On reads it uses each lane's delay to pick the cycle in which that lane's byte is captured. It then hands the controller all nine bytes together in one cycle. On writes it holds back each lane's byte and its enable by that lane's delay, so that every device receives its byte when it is ready.

The delays depend on the board and the modules, so they are measured after every reset and never fixed. A small sequencer trains the lanes one at a time, from lane 0 to lane 8. For a lane, it tries each delay from 0 upward. For each try it sends one probe pulse, which asks the far side to return a known byte, and looks at that lane exactly the trial delay later. The first delay at which the byte matches is kept. A lane that never matches is flagged and left at delay 0. Reads are accepted only after training has finished.

Top module: `lvl_fly_by_level`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, trainDone, trnProbe, rdValid and every laneErr and wrLaneEn bit are 0, and every lane delay is 0.
- R2: The first probe pulse comes in the cycle after the first clock edge out of reset. Each trial lasts exactly 8 cycles and begins with a one-cycle probe pulse. In the trial for delay d, the selected lane's byte is sampled d cycles after that trial's probe.
- R3: A lane's trained delay is the smallest d in 0..7 at which the lane's byte equals 0xA5 in the cycle d cycles after a probe. Trials for larger delays are skipped once the lane matches.
- R4: A lane that finds no 0xA5 at any delay from 0 to 7 sets its laneErr bit and keeps delay 0.
- R5: Lanes are trained in order 0 to 8. Each lane's result becomes visible at the end of that lane's last trial. trainDone rises 8 times the total trial count cycles after the first probe and then stays high. No probe follows it.
- R6: Every reset clears all delays and error flags and runs the full training again, so that new lane timing gives new results.
- R7: A read started by rdStart in cycle t captures lane i from rdDq in cycle t + delay(i). rdValid is high for one cycle, cycle t + maxDelay + 1, and in that cycle rdData carries all nine captured bytes.
- R8: rdStart is ignored before trainDone and while an earlier read is still collecting lanes. A new read is accepted from cycle t + maxDelay + 1 on.
- R9: wrValid and wrData given in cycle t come out on lane i in cycle t + delay(i): wrLaneEn(i) is high and wrLaneDq carries that lane's byte. A lane with delay 0 passes the write through in the same cycle. The lane's data is 0 whenever its enable is low.
- R10: Lane i occupies bits [8i+7:8i] of rdDq, rdData, wrData and wrLaneDq, bits [3i+2:3i] of laneDelay, and bit i of laneErr and wrLaneEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous reset, active low; starts training on release |
| rdStart | input | 1 | Marks the reference cycle of a read burst |
| rdDq | input | 72 | Raw read bytes from the bus, all lanes |
| rdValid | output | 1 | One-cycle pulse when all lanes of a read are captured |
| rdData | output | 72 | Aligned read bytes |
| wrValid | input | 1 | Write byte group is present |
| wrData | input | 72 | Write bytes, all lanes |
| wrLaneEn | output | 9 | Per-lane delayed write enable |
| wrLaneDq | output | 72 | Per-lane delayed write bytes |
| trnProbe | output | 1 | One-cycle request to send the training byte |
| trainDone | output | 1 | All lanes trained |
| laneDelay | output | 27 | Trained delay per lane |
| laneErr | output | 9 | Lane found no match |

## Verification
Some properties are checked by assertions on every cycle. Probe pulses are never adjacent. trainDone stays high once it rises, and no probe or delay load follows it. The delays stay frozen after training. No read completes before training ends. An errored lane holds delay 0, and a lane trained to delay one shows each write on the following cycle. Other behaviour depends on how the lanes answer, and only the bench scenarios show it. These are that the first matching delay is the one kept, skipped trials and the exact cycle in which trainDone rises, results that change after a second reset, reads ignored while busy or untrained, and the byte-for-byte alignment of reads and writes across different delay profiles, including the profile where every delay is zero.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
  localparam int unsigned LANE_N  = 9;
  localparam int unsigned DLY_W   = 3;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned LANE_IW = $clog2(LANE_N);

  // strobes from the training sequencer to the lane datapath
  typedef struct packed {
    logic               probe;
    logic               load;
    logic               loadErr;
    logic [LANE_IW-1:0] lane;
    logic [DLY_W-1:0]   dly;
  } trnStrobe_t;
endpackage

// File: rtl/lvl_train_ctrl.sv
module lvl_train_ctrl
  import lvl_pkg::*;
#(
  parameter int unsigned LANES = LANE_N,
  parameter int unsigned DW    = DLY_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       laneHit,
  output trnStrobe_t strobe,
  output logic       trainDone
);
  localparam logic [DW-1:0]      MAXD     = '1;
  localparam logic [LANE_IW-1:0] LASTLANE = LANE_IW'(LANES - 1);

  typedef enum logic [1:0] {S_IDLE, S_SWEEP, S_DONE} state_t;
  state_t             state;
  logic [DW-1:0]      cnt, dly;
  logic [LANE_IW-1:0] lane;
  logic               hit;

  logic sampleNow, found, trialEnd, laneFinish;
  assign sampleNow  = (state == S_SWEEP) && (cnt == dly);
  assign found      = hit || (sampleNow && laneHit);
  assign trialEnd   = (state == S_SWEEP) && (cnt == MAXD);
  assign laneFinish = trialEnd && (found || dly == MAXD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      dly   <= '0;
      lane  <= '0;
      hit   <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          state <= S_SWEEP;
          cnt   <= '0;
        end
        S_SWEEP: begin
          if (sampleNow && laneHit) hit <= 1'b1;
          if (trialEnd) begin
            cnt <= '0;
            hit <= 1'b0;
            if (laneFinish) begin
              dly <= '0;
              if (lane == LASTLANE) state <= S_DONE;
              else                  lane  <= lane + 1'b1;
            end else begin
              dly <= dly + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DONE: state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.probe   = (state == S_SWEEP) && (cnt == '0);
    strobe.load    = laneFinish;
    strobe.loadErr = !found;
    strobe.lane    = lane;
    strobe.dly     = found ? dly : '0;
  end

  assign trainDone = (state == S_DONE);

  p_probe_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.probe |=> !strobe.probe);
  p_done_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    trainDone |=> trainDone);
  p_quiet_after_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    trainDone |-> (!strobe.probe && !strobe.load));
  p_lane_order_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && lane != LASTLANE) |=> (lane == $past(lane) + 1'b1));
endmodule

// File: rtl/lvl_lane_path.sv
module lvl_lane_path
  import lvl_pkg::*;
#(
  parameter int unsigned LANES   = LANE_N,
  parameter int unsigned DW      = DLY_W,
  parameter int unsigned BW      = BYTE_W,
  parameter logic [BW-1:0] PATTERN = 8'hA5
) (
  input  logic                clk,
  input  logic                rstN,
  input  trnStrobe_t          strobe,
  input  logic                trainDone,
  output logic                laneHit,
  output logic                trnProbe,
  input  logic                rdStart,
  input  logic [LANES*BW-1:0] rdDq,
  output logic                rdValid,
  output logic [LANES*BW-1:0] rdData,
  input  logic                wrValid,
  input  logic [LANES*BW-1:0] wrData,
  output logic [LANES-1:0]    wrLaneEn,
  output logic [LANES*BW-1:0] wrLaneDq,
  output logic [LANES*DW-1:0] laneDelay,
  output logic [LANES-1:0]    laneErr
);
  localparam int unsigned PIPE_N = (1 << DW) - 1;

  logic [BW-1:0] rdByte [LANES];
  logic [DW-1:0] dlyQ   [LANES];
  logic [LANES-1:0] errQ;
  logic [DW-1:0] maxDly;
  logic          rdBusy, rdGo, rdActive;
  logic [DW-1:0] rdCnt, rdPhase;

  assign trnProbe = strobe.probe;

  always_comb begin
    laneHit = 1'b0;
    maxDly  = '0;
    for (int i = 0; i < int'(LANES); i++) begin
      if (LANE_IW'(i) == strobe.lane) laneHit = (rdByte[i] == PATTERN);
      if (dlyQ[i] > maxDly) maxDly = dlyQ[i];
    end
  end

  // read burst sequencing: phase counts cycles since rdStart
  assign rdGo     = rdStart && trainDone && !rdBusy;
  assign rdActive = rdGo || rdBusy;
  assign rdPhase  = rdGo ? '0 : rdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBusy  <= 1'b0;
      rdCnt   <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= 1'b0;
      if (rdActive) begin
        if (rdPhase == maxDly) begin
          rdBusy  <= 1'b0;
          rdValid <= 1'b1;
        end else begin
          rdBusy <= 1'b1;
          rdCnt  <= rdPhase + 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < int'(LANES); i++) begin : g_lane
    logic [BW-1:0] capQ;
    logic [BW:0]   pipe [PIPE_N];
    logic [BW:0]   tap;

    assign rdByte[i] = rdDq[i*BW +: BW];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dlyQ[i] <= '0;
        errQ[i] <= 1'b0;
      end else if (strobe.load && strobe.lane == LANE_IW'(i)) begin
        dlyQ[i] <= strobe.dly;
        errQ[i] <= strobe.loadErr;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) capQ <= '0;
      else if (rdActive && rdPhase == dlyQ[i]) capQ <= rdByte[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int k = 0; k < int'(PIPE_N); k++) pipe[k] <= '0;
      end else begin
        pipe[0] <= {wrValid, wrData[i*BW +: BW]};
        for (int k = 1; k < int'(PIPE_N); k++) pipe[k] <= pipe[k-1];
      end
    end

    assign tap = (dlyQ[i] == '0) ? {wrValid, wrData[i*BW +: BW]}
                                 : pipe[dlyQ[i] - 1'b1];

    assign wrLaneEn[i]          = tap[BW];
    assign wrLaneDq[i*BW +: BW] = tap[BW] ? tap[BW-1:0] : '0;
    assign rdData[i*BW +: BW]   = capQ;
    assign laneDelay[i*DW +: DW] = dlyQ[i];
    assign laneErr[i]           = errQ[i];

    p_err_zero_delay_r4: assert property (@(posedge clk) disable iff (!rstN)
      errQ[i] |-> (dlyQ[i] == '0));
    p_wr_one_late_r9: assert property (@(posedge clk) disable iff (!rstN)
      (trainDone && wrValid && dlyQ[i] == DW'(1)) |=> wrLaneEn[i]);
  end

  p_no_read_untrained_r8: assert property (@(posedge clk) disable iff (!rstN)
    !trainDone |-> !rdValid);
  p_delays_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    trainDone |=> $stable(laneDelay));
endmodule

// File: rtl/lvl_fly_by_level.sv
module lvl_fly_by_level
  import lvl_pkg::*;
#(
  parameter int unsigned   LANES   = LANE_N,
  parameter int unsigned   DW      = DLY_W,
  parameter int unsigned   BW      = BYTE_W,
  parameter logic [BW-1:0] PATTERN = 8'hA5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdStart,
  input  logic [LANES*BW-1:0] rdDq,
  output logic                rdValid,
  output logic [LANES*BW-1:0] rdData,
  input  logic                wrValid,
  input  logic [LANES*BW-1:0] wrData,
  output logic [LANES-1:0]    wrLaneEn,
  output logic [LANES*BW-1:0] wrLaneDq,
  output logic                trnProbe,
  output logic                trainDone,
  output logic [LANES*DW-1:0] laneDelay,
  output logic [LANES-1:0]    laneErr
);
  trnStrobe_t strobe;
  logic       laneHit;

  lvl_train_ctrl #(.LANES(LANES), .DW(DW)) i_ctrl (
    .clk(clk), .rstN(rstN), .laneHit(laneHit),
    .strobe(strobe), .trainDone(trainDone)
  );

  lvl_lane_path #(.LANES(LANES), .DW(DW), .BW(BW), .PATTERN(PATTERN)) i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .trainDone(trainDone),
    .laneHit(laneHit), .trnProbe(trnProbe),
    .rdStart(rdStart), .rdDq(rdDq), .rdValid(rdValid), .rdData(rdData),
    .wrValid(wrValid), .wrData(wrData), .wrLaneEn(wrLaneEn), .wrLaneDq(wrLaneDq),
    .laneDelay(laneDelay), .laneErr(laneErr)
  );
endmodule

// File: tb/test_lvl_fly_by_level.sv
module test_lvl_fly_by_level;
  localparam int LN = 9, BW = 8, DW = 3, MAXD = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, rdStart = 1'b0, wrValid = 1'b0;
  logic [LN*BW-1:0] rdDq = '0, wrData = '0;
  logic rdValid, trnProbe, trainDone;
  logic [LN*BW-1:0] rdData, wrLaneDq;
  logic [LN-1:0] wrLaneEn, laneErr;
  logic [LN*DW-1:0] laneDelay;

  lvl_fly_by_level i_lvl_fly_by_level (
    .clk(clk), .rstN(rstN), .rdStart(rdStart), .rdDq(rdDq),
    .rdValid(rdValid), .rdData(rdData), .wrValid(wrValid), .wrData(wrData),
    .wrLaneEn(wrLaneEn), .wrLaneDq(wrLaneDq), .trnProbe(trnProbe),
    .trainDone(trainDone), .laneDelay(laneDelay), .laneErr(laneErr)
  );

  int total = 0, bad = 0;
  int skew [LN];
  int expDly [LN];
  bit expErr [LN];
  int endCyc [LN];
  int doneCyc, maxD, c, gcyc = 0;
  string tagPre = "";
  bit probeHist [16];
  logic [7:0] drv [16][LN];
  bit drvOn [16][LN];
  bit wvHist [16];
  logic [LN*BW-1:0] wdHist [16];
  int accT; bit accOn;
  bit rdReq, wrReq; logic [LN*BW-1:0] wrVal;

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s%s %s at cycle %0d: actual=%0h expected=%0h", tagPre, req, what, c, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // expected training results derived from the lane skews
  task automatic plan();
    int k = 0;
    maxD = 0;
    for (int j = 0; j < LN; j++) begin
      if (skew[j] <= MAXD) begin k += skew[j] + 1; expDly[j] = skew[j]; expErr[j] = 0; end
      else begin k += MAXD + 1; expDly[j] = 0; expErr[j] = 1; end
      endCyc[j] = 8 * k;
      if (expDly[j] > maxD) maxD = expDly[j];
    end
    doneCyc = 8 * k;
  endtask

  task automatic step();
    bit expV; int expT;
    logic [LN*BW-1:0] expRd, expWd, dq;
    logic [LN-1:0] expEn, expErrV;
    logic [LN*DW-1:0] expDv;
    @(negedge clk);
    gcyc++;
    if (gcyc > 20000) begin total++; bad++; $display("FAIL watchdog expired"); finish_run(); end
    if (rstN) c++;
    probeHist[c & 15] = rstN && (c >= 0) && trnProbe;
    expV = accOn && (c == accT + maxD + 1);
    expT = accT;
    if (rstN && rdReq && c >= doneCyc && (!accOn || c > accT + maxD)) begin
      accT = c; accOn = 1;
      for (int j = 0; j < LN; j++) begin
        drv[(c + expDly[j]) & 15][j] = {4'(j), 4'(c)};
        drvOn[(c + expDly[j]) & 15][j] = 1;
      end
    end
    for (int j = 0; j < LN; j++) begin
      logic [7:0] b;
      b = 8'hA4;
      if (skew[j] <= MAXD && c - skew[j] >= 0 && probeHist[(c - skew[j]) & 15]) b = 8'hA5;
      if (c >= 0 && drvOn[c & 15][j]) begin b = drv[c & 15][j]; drvOn[c & 15][j] = 0; end
      dq[j*BW +: BW] = b;
    end
    rdDq = dq;
    rdStart = rdReq; wrValid = wrReq; wrData = wrVal;
    if (c >= 0) begin wvHist[c & 15] = wrReq; wdHist[c & 15] = wrVal; end
    #1;
    for (int j = 0; j < LN; j++) begin
      bit en;
      expDv[j*DW +: DW] = (c >= endCyc[j]) ? DW'(expDly[j]) : '0;
      expErrV[j] = (c >= endCyc[j]) ? expErr[j] : 1'b0;
      expRd[j*BW +: BW] = {4'(j), 4'(expT)};
      en = (c - expDly[j] >= 0) ? wvHist[(c - expDly[j]) & 15] : 1'b0;
      expEn[j] = en;
      expWd[j*BW +: BW] = en ? wdHist[(c - expDly[j]) & 15][j*BW +: BW] : '0;
    end
    if (c <= 0) begin
      chk("R1", {127'd0, trainDone}, 128'd0, "trainDone");
      chk("R1", {127'd0, rdValid}, 128'd0, "rdValid");
    end
    chk("R2", {127'd0, trnProbe}, {127'd0, (c >= 0 && c < doneCyc && c % 8 == 0)}, "trnProbe");
    chk("R5", {127'd0, trainDone}, {127'd0, (c >= doneCyc)}, "trainDone");
    chk("R3 R10", {101'd0, laneDelay}, {101'd0, expDv}, "laneDelay");
    chk("R4", {119'd0, laneErr}, {119'd0, expErrV}, "laneErr");
    chk("R7 R8", {127'd0, rdValid}, {127'd0, expV}, "rdValid");
    if (expV) chk("R7 R10", {56'd0, rdData}, {56'd0, expRd}, "rdData");
    chk("R9", {119'd0, wrLaneEn}, {119'd0, expEn}, "wrLaneEn");
    chk("R9 R10", {56'd0, wrLaneDq}, {56'd0, expWd}, "wrLaneDq");
  endtask

  task automatic cyc(bit r, bit w, logic [LN*BW-1:0] v);
    rdReq = r; wrReq = w; wrVal = v;
    step();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; c = -1; accOn = 0;
    for (int s = 0; s < 16; s++) begin
      probeHist[s] = 0; wvHist[s] = 0; wdHist[s] = '0;
      for (int j = 0; j < LN; j++) drvOn[s][j] = 0;
    end
    repeat (3) cyc(0, 0, '0);
    rstN = 1;
  endtask

  task automatic scenario();
    plan();
    doReset();
    // R8: reads requested during training are ignored
    while (c < doneCyc + 2) cyc(c >= 10 && c < 13, 0, '0);
    // read, a second request while busy, then one at the earliest legal cycle
    cyc(1, 0, '0);
    cyc(1, 0, '0);
    repeat (maxD > 0 ? maxD - 1 : 0) cyc(0, 0, '0);
    cyc(1, 0, '0);
    repeat (10) cyc(0, 0, '0);
    // writes: a run, a gap, then mixed with a read
    for (int k = 0; k < 6; k++) cyc(0, k != 2, {$urandom, $urandom, $urandom});
    repeat (3) cyc(0, 0, '0);
    cyc(1, 1, {$urandom, $urandom, $urandom});
    cyc(0, 1, {$urandom, $urandom, $urandom});
    repeat (12) cyc(0, 0, '0);
  endtask

  initial begin
    rdReq = 0; wrReq = 0; wrVal = '0;
    for (int j = 0; j < LN; j++) skew[j] = 0;
    plan(); c = -1;
    // profile 1: delay grows along the chain, last lane never answers
    for (int j = 0; j < LN; j++) skew[j] = (j < 8) ? j : 99;
    scenario();
    // profile 2: new timing after a fresh reset, error lane mid-chain
    tagPre = "R6 ";
    skew = '{3, 3, 1, 0, 7, 2, 99, 5, 4};
    scenario();
    // profile 3: every lane at delay zero, reads back to back
    for (int j = 0; j < LN; j++) skew[j] = 0;
    scenario();
    repeat (4) cyc(1, 1, {$urandom, $urandom, $urandom});
    repeat (4) cyc(0, 0, '0);
    finish_run();
  end
endmodule